// File: doc/BRIEF.md
# Host Register Bank with Power Sequencing

This block gives a host microcontroller a byte-wide, memory-mapped path into a small bank of control registers. The host presents a 6-bit register address, an active-low select and active-low read and write strobes, and exchanges bytes over an 8-bit shared three-state bus. A write lands when the write strobe rises while the select is held low. The bus is driven only during a selected read, and released otherwise.

Two registers are implemented. A write-only power register holds one enable bit per sub-circuit: clock buffer, baseband, op-amp pair, regulator, and four receive/transmit RF and IF sections. A readable control register holds a soft-reset trigger together with a bias-enable bit and a register-retention bit. The soft reset clears the bank but spares the regulator, bias and retention bits. Each enable output is the register bit gated by its prerequisites. Blocks that need the clock are held off until the clock buffer is enabled. Everything except the regulator and bias is held off until the regulator is on. Any attempt to break these rules sets a sticky error flag.

Top module: `pwr_regbank`

## Requirements
- R1: An asserted `rst_n` (low, asynchronous) clears every register bit and the error flag. All enable outputs are 0 and address 5 reads 0x00.
- R2: A write happens on the rising edge of `wr_n` (sampled by `clk`) only if `cs_n` is low at that edge. A strobe with `cs_n` high changes nothing.
- R3: `data` is driven only while both `cs_n` and `rd_n` are low. Otherwise it is high impedance.
- R4: Address 4 is write-only and reads 0x00. Every address other than 5 reads 0x00.
- R5: Address 5 reads {4'b0, soft-reset bit 3, 1'b0, bias bit 1, retention bit 0}. Written values of bits 1 and 0 read back unchanged.
- R6: Writing address 5 with bit 3 set applies a soft reset on the next clock. It clears power bits 7,6,5,3,2,1,0 and leaves power bit 4 (regulator), bias and retention at their written values.
- R7: The soft-reset bit is 1 for exactly one clock, so it reads back 0 after the write.
- R8: Power register bits 6 (baseband), 3 (IF receive), 2 (RF1 receive), 1 (RF2 receive) and 0 (transmit) reach their outputs only while bit 7 (clock) and bit 4 (regulator) are both 1. Otherwise the output is 0.
- R9: `en_clk` (bit 7) and `en_opamp` (bit 5) are 1 only while bit 4 (regulator) is 1. `en_vreg` and `en_vbias` follow their bits directly.
- R10: `seq_err` is set on the clock after either of two conditions holds. The first is a clock-needing bit or the soft-reset bit being set while bit 7 is 0. The second is any power bit other than bit 4 being set while bit 4 is 0. Once set, `seq_err` stays 1 until `rst_n`.
- R11: With the regulator and clock enabled, writing 0xFF to address 4 drives every power enable output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| addr | input | 6 | Register address |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; write on rising edge |
| rd_n | input | 1 | Read strobe, active low |
| data | inout | 8 | Three-state host data bus |
| en_clk | output | 1 | Clock buffer enable |
| en_bband | output | 1 | Baseband enable |
| en_opamp | output | 1 | Op-amp pair enable |
| en_vreg | output | 1 | Regulator enable |
| en_rx_if | output | 1 | IF receive section enable |
| en_rx_rf1 | output | 1 | First RF receive section enable |
| en_rx_rf2 | output | 1 | Second RF receive section enable |
| en_tx | output | 1 | Transmit RF/IF enable |
| en_vbias | output | 1 | Bias enable |
| keep_regs | output | 1 | Register retention setting |
| seq_err | output | 1 | Sticky sequencing-error flag |

## Verification
The in-module assertions check every cycle that no clock-needing enable is high without the clock enable, and that nothing beyond the regulator and bias is high without the regulator. They also check that the soft-reset bit never lasts two cycles, that a soft reset keeps the regulator and bias bits and drops the rest, and that the error flag never falls outside hard reset. The directed scenarios show the parts that need a host transaction. These are the strobe-edge write with and without select, the bus release, the read values of each address and the rule violations that trip the flag.

// File: rtl/pwr_regbank.sv
module pwr_regbank #(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter logic [AW-1:0] PWR_ADDR = 6'h04,
  parameter logic [AW-1:0] CTL_ADDR = 6'h05
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  inout  wire  [DW-1:0] data,
  output logic          en_clk,
  output logic          en_bband,
  output logic          en_opamp,
  output logic          en_vreg,
  output logic          en_rx_if,
  output logic          en_rx_rf1,
  output logic          en_rx_rf2,
  output logic          en_tx,
  output logic          en_vbias,
  output logic          keep_regs,
  output logic          seq_err
);

  localparam int B_CLK = 7, B_BB = 6, B_OP = 5, B_VREG = 4;
  localparam int B_RXIF = 3, B_RF1 = 2, B_RF2 = 1, B_TX = 0;
  localparam int C_SRST = 3, C_VBIAS = 1, C_KEEP = 0;
  localparam logic [DW-1:0] PWR_KEEP_MASK = DW'(1) << B_VREG;

  logic [DW-1:0] pwr;
  logic          srst, vbias, keep;
  logic          wr_q, err_q;

  wire wr_hit   = wr_n & ~wr_q & ~cs_n;
  wire rd_act   = ~cs_n & ~rd_n;
  wire vreg_on  = pwr[B_VREG];
  wire clk_on   = pwr[B_CLK];
  wire need_clk = srst | pwr[B_BB] | pwr[B_RXIF] | pwr[B_RF1] | pwr[B_RF2] | pwr[B_TX];
  wire beyond_vreg = |(pwr & ~PWR_KEEP_MASK);
  wire viol     = (need_clk & ~clk_on) | (beyond_vreg & ~vreg_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr   <= '0;
      srst  <= 1'b0;
      vbias <= 1'b0;
      keep  <= 1'b0;
    end else if (srst) begin
      pwr  <= pwr & PWR_KEEP_MASK;
      srst <= 1'b0;
    end else if (wr_hit) begin
      if (addr == PWR_ADDR) pwr <= data;
      if (addr == CTL_ADDR) begin
        srst  <= data[C_SRST];
        vbias <= data[C_VBIAS];
        keep  <= data[C_KEEP];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    err_q <= 1'b0;
    else if (viol) err_q <= 1'b1;
  end

  logic [DW-1:0] rdata;
  always_comb begin
    rdata = '0;
    if (addr == CTL_ADDR) begin
      rdata[C_SRST]  = srst;
      rdata[C_VBIAS] = vbias;
      rdata[C_KEEP]  = keep;
    end
  end

  assign data = rd_act ? rdata : {DW{1'bz}};

  wire clk_gate = clk_on & vreg_on;

  assign en_vreg   = vreg_on;
  assign en_clk    = clk_on & vreg_on;
  assign en_opamp  = pwr[B_OP] & vreg_on;
  assign en_bband  = pwr[B_BB] & clk_gate;
  assign en_rx_if  = pwr[B_RXIF] & clk_gate;
  assign en_rx_rf1 = pwr[B_RF1] & clk_gate;
  assign en_rx_rf2 = pwr[B_RF2] & clk_gate;
  assign en_tx     = pwr[B_TX] & clk_gate;
  assign en_vbias  = vbias;
  assign keep_regs = keep;
  assign seq_err   = err_q;

  a_r8_clk_first: assert property (@(posedge clk) disable iff (!rst_n)
    (en_bband | en_rx_if | en_rx_rf1 | en_rx_rf2 | en_tx) |-> en_clk);

  a_r9_vreg_first: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clk | en_opamp) |-> en_vreg);

  a_r7_srst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !srst);

  a_r6_srst_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (en_vreg == $past(pwr[B_VREG])) && (en_vbias == $past(vbias))
             && !en_clk && !en_opamp);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> $past(viol));

endmodule

// File: tb/pwr_regbank_bench.sv
`timescale 1ns/1ps
module pwr_regbank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic       drv = 1'b0;
  logic [7:0] wdat = '0;
  tri1  [7:0] data;
  logic en_clk, en_bband, en_opamp, en_vreg, en_rx_if, en_rx_rf1, en_rx_rf2, en_tx;
  logic en_vbias, keep_regs, seq_err;
  int   n_chk = 0, n_bad = 0;

  assign data = drv ? wdat : 8'bz;
  always #2.5 clk = ~clk;

  pwr_regbank u_pwr_regbank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .data(data), .en_clk(en_clk), .en_bband(en_bband), .en_opamp(en_opamp),
    .en_vreg(en_vreg), .en_rx_if(en_rx_if), .en_rx_rf1(en_rx_rf1), .en_rx_rf2(en_rx_rf2),
    .en_tx(en_tx), .en_vbias(en_vbias), .keep_regs(keep_regs), .seq_err(seq_err));

  wire [7:0] enables = {en_clk, en_bband, en_opamp, en_vreg, en_rx_if, en_rx_rf1, en_rx_rf2, en_tx};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [5:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    addr = a; wdat = d; drv = 1'b1; cs_n = ~sel; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; drv = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic host_rd(input logic [5:0] a, output logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    addr = a; cs_n = ~sel; rd_n = 1'b0;
    #1 d = data;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic hard_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    hard_reset();
    chk("R1 enables", enables, 8'h00);
    chk("R1 err/bias/keep", {5'b0, seq_err, en_vbias, keep_regs}, 8'h00);
    host_rd(6'h05, r); chk("R1 ctl read", r, 8'h00);
  endtask

  task automatic t_bus();
    logic [7:0] r;
    #1 chk("R3 idle bus released", data, 8'hFF);
    host_rd(6'h05, r, 1'b0); chk("R3 rd without select released", r, 8'hFF);
    host_wr(6'h04, 8'h10, 1'b0);
    chk("R2 write with cs_n high ignored", enables, 8'h00);
  endtask

  task automatic t_power_up();
    logic [7:0] r;
    host_wr(6'h04, 8'h10); chk("R2 vreg write", enables, 8'h10);
    host_wr(6'h04, 8'h90); chk("R9 clock after vreg", enables, 8'h90);
    host_wr(6'h04, 8'hFF); chk("R11 all on", enables, 8'hFF);
    chk("R10 no error on legal order", {7'b0, seq_err}, 8'h00);
    host_rd(6'h04, r); chk("R4 write-only read", r, 8'h00);
    host_rd(6'h3F, r); chk("R4 unmapped read", r, 8'h00);
    host_wr(6'h05, 8'h03); host_rd(6'h05, r); chk("R5 ctl readback", r, 8'h03);
    chk("R9 bias/keep outputs", {6'b0, en_vbias, keep_regs}, 8'h03);
  endtask

  task automatic t_soft_reset();
    logic [7:0] r;
    host_wr(6'h05, 8'h0B);
    chk("R6 soft reset enables", enables, 8'h10);
    chk("R6 bias/keep kept", {6'b0, en_vbias, keep_regs}, 8'h03);
    host_rd(6'h05, r); chk("R7 srst self-clear", r, 8'h03);
  endtask

  task automatic t_clock_rule();
    host_wr(6'h04, 8'h14);
    chk("R8 rf1 gated without clock", {7'b0, en_rx_rf1}, 8'h00);
    chk("R10 error on missing clock", {7'b0, seq_err}, 8'h01);
    host_wr(6'h04, 8'h94);
    chk("R8 rf1 with clock", enables, 8'h94);
    chk("R10 error sticky", {7'b0, seq_err}, 8'h01);
    hard_reset();
    chk("R10 error cleared by hard reset", {7'b0, seq_err}, 8'h00);
  endtask

  task automatic t_vreg_rule();
    host_wr(6'h04, 8'hA0);
    chk("R9 clk/opamp gated without vreg", enables, 8'h00);
    chk("R10 error on missing vreg", {7'b0, seq_err}, 8'h01);
    hard_reset();
    host_wr(6'h04, 8'h10);
    host_wr(6'h05, 8'h08);
    chk("R10 soft reset without clock errors", {7'b0, seq_err}, 8'h01);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_bus();
    t_power_up();
    t_soft_reset();
    t_clock_rule();
    t_vreg_rule();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule